// File: doc/BRIEF.md
# Row-Parallel Update, Shrink and Store Sequencer

This block runs the write-back half of one iteration of a sparse estimation loop. Two vectors, the working vector v and the estimate beta, are held row by row in M dual-port memories, one lane per memory. Port B of each memory reads a row of v. Every lane adds a shared correction term d to its v word. It then passes the sum through a single soft-threshold stage. A sequencer writes the updated v row and then the matching beta row through port A. While the beta row is being written, the next v row is already arriving from port B, so the steady state costs two cycles per row.

The same threshold stage serves both results. For the v write it runs with a threshold of zero and returns its input unchanged. For the beta write it runs with the programmed threshold. A pass is framed by one cycle in which the block takes address control and one in which it hands control back, with a one-cycle done pulse. The correction term d comes from outside the block. So do the threshold, the row count, the number of active lanes in the final row and the base addresses of the two vector regions. All of them are captured when the pass starts.

Cycle numbering used below: cycle 0 is the clock cycle that follows the rising edge at which `start` is accepted in state IDLE. The states are IDLE, GRANT (cycle 0), FETCH (cycle 1), PRIME (cycle 2), WR_V and WR_B alternating (row r in cycles 3+2r and 4+2r), and RELEASE (cycle 2R+3). The transitions are IDLE to GRANT on start, then GRANT to FETCH, FETCH to PRIME, PRIME to WR_V and WR_V to WR_B. WR_B goes back to WR_V while rows remain and to RELEASE after the last row. RELEASE always returns to IDLE. R is the effective row count.

Top module: `vb_update_seq`

## Requirements
- R1: While reset is asserted and in IDLE after reset, `b_rd_en`, every bit of `a_wr_en` and `done` are low.
- R2: With effective row count R (`row_cnt`, where zero is taken as one), `done` is high for exactly one cycle, in cycle 2R+3, so a pass occupies 2R+4 cycles. In that cycle there is no read and no write.
- R3: Port B reads row 0 of v at address `v_base` in cycle 1. It reads row r+1 at `v_base`+r+1 in cycle 3+2r for r < R-1, and it reads in no other cycle. Read data is expected one cycle after the read.
- R4: In cycle 3+2r port A writes v row r to address `v_base`+r. Each enabled lane m carries the 20-bit wrap-around sum of its read word and `d`. Lane m sits at bits [20m+19:20m] of the row buses.
- R5: In cycle 4+2r port A writes beta row r to address `b_base`+r. Each enabled lane carries shrink(v_new, `thresh`), where shrink(x,t) = sign(x)·max(|x|−t,0). Here x is 20-bit two's complement and t is unsigned.
- R6: The shrink clamps at zero when |x| ≤ t and restores the sign otherwise. With t = 0 it returns x unchanged, including the most negative value −2^19. A large t forces beta to zero.
- R7: On every row before the last, all M lanes write. On the last row, lane m writes only if m < `tail_cnt`, where a `tail_cnt` of zero or above M is taken as M. Disabled lanes leave both memory words untouched.
- R8: A `start` pulse during a pass is ignored. Changes to `d`, `thresh`, `row_cnt`, `tail_cnt` and either base after the start cycle do not change that pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a pass (accepted in IDLE only) |
| d | input | W | Correction term added to every enabled v word |
| thresh | input | W | Unsigned threshold for the beta pass |
| row_cnt | input | TW | Number of rows to process (0 taken as 1) |
| tail_cnt | input | CW | Active lanes in the final row (0 or >M taken as M) |
| v_base | input | AW | Base address of the v region |
| b_base | input | AW | Base address of the beta region |
| b_rd_en | output | 1 | Port B read strobe |
| b_rd_addr | output | AW | Port B read address |
| b_rd_data | input | M*W | Port B read data, one cycle after the strobe |
| a_wr_en | output | M | Port A per-lane write enables |
| a_wr_addr | output | AW | Port A write address |
| a_wr_data | output | M*W | Port A write data |
| done | output | 1 | One-cycle end-of-pass pulse |

## Verification
The bench targets the single-row pass and a zero row count. A design that got these wrong would write twice or read a row past the end. It drives lane counts of one, M, zero and above M, where a broken mask would corrupt lanes past the vector end or drop valid ones. It uses v words at −2^19, at ±thresh and with sums that overflow 20 bits. A shrink that saturated, or that applied the threshold on the v pass, would show up in the stored words. A start pulse and changed inputs in mid-pass would restart the sequence or mix two configurations if the capture were missing.

// File: rtl/vb_pkg.sv
package vb_pkg;

    // Sequencer states, in the order a pass visits them.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_GRANT   = 3'd1,
        ST_FETCH   = 3'd2,
        ST_PRIME   = 3'd3,
        ST_WR_V    = 3'd4,
        ST_WR_B    = 3'd5,
        ST_RELEASE = 3'd6
    } seq_state_t;

endpackage

// File: rtl/vb_shrink.sv
// Soft threshold on a two's-complement word; threshold is unsigned.
module vb_shrink #(
    parameter int W = 20
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] th,
    output logic [W-1:0] y
);

    logic         neg;
    logic [W-1:0] mag_in;
    logic [W-1:0] mag_out;

    always_comb begin
        neg    = x[W-1];
        // Unsigned magnitude: -(-2^(W-1)) is 2^(W-1), still representable.
        mag_in = neg ? (~x + 1'b1) : x;
        if (mag_in > th) begin
            mag_out = mag_in - th;
        end else begin
            mag_out = '0;
        end
        y = neg ? (~mag_out + 1'b1) : mag_out;
    end

endmodule

// File: rtl/vb_lane.sv
// One memory lane: adder, shared threshold stage and its output register.
module vb_lane #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         sel_update,
    input  logic [W-1:0] d,
    input  logic [W-1:0] lam,
    input  logic [W-1:0] rd_word,
    output logic [W-1:0] sh_q
);

    logic [W-1:0] sum;
    logic [W-1:0] sh_in;
    logic [W-1:0] sh_th;
    logic [W-1:0] sh_out;

    always_comb begin
        sum = rd_word + d;
        // Update step: fresh sum with zero threshold (identity).
        // Beta step: stored v_new again, this time with the real threshold.
        if (sel_update) begin
            sh_in = sum;
            sh_th = '0;
        end else begin
            sh_in = sh_q;
            sh_th = lam;
        end
    end

    vb_shrink #(.W(W)) u_shrink (
        .x  (sh_in),
        .th (sh_th),
        .y  (sh_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= sh_out;
        end
    end

endmodule

// File: rtl/vb_seq_ctrl.sv
// Pass sequencer: state machine, row counter, captured configuration.
module vb_seq_ctrl
    import vb_pkg::*;
#(
    parameter int M  = 4,
    parameter int W  = 20,
    parameter int AW = 6,
    parameter int TW = 5,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [W-1:0]  d,
    input  logic [W-1:0]  thresh,
    input  logic [TW-1:0] row_cnt,
    input  logic [CW-1:0] tail_cnt,
    input  logic [AW-1:0] v_base,
    input  logic [AW-1:0] b_base,
    output logic          b_rd_en,
    output logic [AW-1:0] b_rd_addr,
    output logic [M-1:0]  a_wr_en,
    output logic [AW-1:0] a_wr_addr,
    output logic          done,
    output logic          lane_load,
    output logic          lane_sel_update,
    output logic [W-1:0]  d_q,
    output logic [W-1:0]  lam_q
);

    localparam logic [CW-1:0] FULL_TAIL = CW'(M);

    seq_state_t    state_q;
    seq_state_t    state_d;
    logic [TW-1:0] row_q;
    logic [TW-1:0] last_q;
    logic [CW-1:0] tail_q;
    logic [AW-1:0] vb_q;
    logic [AW-1:0] bb_q;
    logic [M-1:0]  tail_mask;
    logic          is_last;
    logic          accept;

    assign accept  = (state_q == ST_IDLE) && start;
    assign is_last = (row_q == last_q);

    // Thermometer enable for the final row: lane m active when m < tail_q.
    for (genvar m = 0; m < M; m++) begin : g_mask
        localparam logic [CW-1:0] LANE_IDX = CW'(m);
        assign tail_mask[m] = (LANE_IDX < tail_q);
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_GRANT;
            ST_GRANT:   state_d = ST_FETCH;
            ST_FETCH:   state_d = ST_PRIME;
            ST_PRIME:   state_d = ST_WR_V;
            ST_WR_V:    state_d = ST_WR_B;
            ST_WR_B:    state_d = is_last ? ST_RELEASE : ST_WR_V;
            ST_RELEASE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Row counter: cleared on the first read, advanced after each beta write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (state_q == ST_FETCH) begin
            row_q <= '0;
        end else if (state_q == ST_WR_B && !is_last) begin
            row_q <= row_q + 1'b1;
        end
    end

    // Configuration is frozen for the whole pass at the accepting edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= '0;
            tail_q <= FULL_TAIL;
            vb_q   <= '0;
            bb_q   <= '0;
            d_q    <= '0;
            lam_q  <= '0;
        end else if (accept) begin
            last_q <= (row_cnt == '0) ? '0 : (row_cnt - 1'b1);
            tail_q <= (tail_cnt == '0 || tail_cnt > FULL_TAIL) ? FULL_TAIL : tail_cnt;
            vb_q   <= v_base;
            bb_q   <= b_base;
            d_q    <= d;
            lam_q  <= thresh;
        end
    end

    // Outputs, decoded from the state and the row counter.
    always_comb begin
        b_rd_en         = 1'b0;
        b_rd_addr       = vb_q;
        a_wr_en         = '0;
        a_wr_addr       = vb_q + AW'(row_q);
        done            = 1'b0;
        lane_load       = 1'b0;
        lane_sel_update = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_GRANT: begin
            end
            ST_FETCH: begin
                b_rd_en   = 1'b1;
                b_rd_addr = vb_q;
            end
            ST_PRIME: begin
                lane_load       = 1'b1;
                lane_sel_update = 1'b1;
            end
            ST_WR_V: begin
                a_wr_en   = is_last ? tail_mask : '1;
                a_wr_addr = vb_q + AW'(row_q);
                lane_load = 1'b1;
                b_rd_en   = !is_last;
                b_rd_addr = vb_q + AW'(row_q) + 1'b1;
            end
            ST_WR_B: begin
                a_wr_en         = is_last ? tail_mask : '1;
                a_wr_addr       = bb_q + AW'(row_q);
                lane_load       = 1'b1;
                lane_sel_update = 1'b1;
            end
            ST_RELEASE: begin
                done = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/vb_update_seq.sv
// Top: sequencer plus M lanes.
module vb_update_seq #(
    parameter int M  = 4,
    parameter int W  = 20,
    parameter int AW = 6,
    parameter int TW = 5,
    parameter int CW = $clog2(M + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [W-1:0]    d,
    input  logic [W-1:0]    thresh,
    input  logic [TW-1:0]   row_cnt,
    input  logic [CW-1:0]   tail_cnt,
    input  logic [AW-1:0]   v_base,
    input  logic [AW-1:0]   b_base,
    output logic            b_rd_en,
    output logic [AW-1:0]   b_rd_addr,
    input  logic [M*W-1:0]  b_rd_data,
    output logic [M-1:0]    a_wr_en,
    output logic [AW-1:0]   a_wr_addr,
    output logic [M*W-1:0]  a_wr_data,
    output logic            done
);

    logic         lane_load;
    logic         lane_sel_update;
    logic [W-1:0] d_q;
    logic [W-1:0] lam_q;

    vb_seq_ctrl #(
        .M(M), .W(W), .AW(AW), .TW(TW), .CW(CW)
    ) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .start           (start),
        .d               (d),
        .thresh          (thresh),
        .row_cnt         (row_cnt),
        .tail_cnt        (tail_cnt),
        .v_base          (v_base),
        .b_base          (b_base),
        .b_rd_en         (b_rd_en),
        .b_rd_addr       (b_rd_addr),
        .a_wr_en         (a_wr_en),
        .a_wr_addr       (a_wr_addr),
        .done            (done),
        .lane_load       (lane_load),
        .lane_sel_update (lane_sel_update),
        .d_q             (d_q),
        .lam_q           (lam_q)
    );

    for (genvar m = 0; m < M; m++) begin : g_lane
        vb_lane #(.W(W)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (lane_load),
            .sel_update (lane_sel_update),
            .d          (d_q),
            .lam        (lam_q),
            .rd_word    (b_rd_data[m*W +: W]),
            .sh_q       (a_wr_data[m*W +: W])
        );
    end

endmodule

// File: rtl/vb_update_seq_chk.sv
// Port-level protocol checks, bound to the top.
module vb_update_seq_chk #(
    parameter int M  = 4,
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic          b_rd_en,
    input logic [AW-1:0] b_rd_addr,
    input logic [M-1:0]  a_wr_en,
    input logic [AW-1:0] a_wr_addr
);

    logic [M-1:0] wr_inc;
    assign wr_inc = a_wr_en + 1'b1;

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!b_rd_en && a_wr_en == '0));

    // R3
    read_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_rd_en |=> !b_rd_en);

    // R3
    port_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_rd_en && a_wr_en != '0) |-> (b_rd_addr != a_wr_addr));

    // R7
    lane_thermo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr_en & wr_inc) == '0);

endmodule

bind vb_update_seq vb_update_seq_chk #(.M(M), .AW(AW)) u_vb_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .b_rd_en   (b_rd_en),
    .b_rd_addr (b_rd_addr),
    .a_wr_en   (a_wr_en),
    .a_wr_addr (a_wr_addr)
);

// File: tb/test_vb_update_seq.sv
`timescale 1ns/1ps
module test_vb_update_seq;

    localparam int M  = 4;
    localparam int W  = 20;
    localparam int AW = 6;
    localparam int TW = 5;
    localparam int CW = 3;
    localparam int DEPTH = 1 << AW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [W-1:0]    d = '0;
    logic [W-1:0]    thresh = '0;
    logic [TW-1:0]   row_cnt = '0;
    logic [CW-1:0]   tail_cnt = '0;
    logic [AW-1:0]   v_base = '0;
    logic [AW-1:0]   b_base = '0;
    logic            b_rd_en;
    logic [AW-1:0]   b_rd_addr;
    logic [M*W-1:0]  b_rd_data;
    logic [M-1:0]    a_wr_en;
    logic [AW-1:0]   a_wr_addr;
    logic [M*W-1:0]  a_wr_data;
    logic            done;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 0;

    logic [M*W-1:0] mem  [0:DEPTH-1];
    logic [M*W-1:0] snap [0:DEPTH-1];
    logic [M*W-1:0] expm [0:DEPTH-1];
    logic [M*W-1:0] rd_q = '0;

    always #4 clk = ~clk;

    vb_update_seq #(.M(M), .W(W), .AW(AW), .TW(TW), .CW(CW)) i_vb_update_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .d(d), .thresh(thresh),
        .row_cnt(row_cnt), .tail_cnt(tail_cnt), .v_base(v_base), .b_base(b_base),
        .b_rd_en(b_rd_en), .b_rd_addr(b_rd_addr), .b_rd_data(b_rd_data),
        .a_wr_en(a_wr_en), .a_wr_addr(a_wr_addr), .a_wr_data(a_wr_data),
        .done(done)
    );

    // Dual-port memory model: registered read on B, per-lane write on A.
    assign b_rd_data = rd_q;
    always @(posedge clk) begin
        if (b_rd_en) rd_q <= mem[b_rd_addr];
        for (int m = 0; m < M; m++) begin
            if (a_wr_en[m]) mem[a_wr_addr][m*W +: W] <= a_wr_data[m*W +: W];
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [M*W-1:0] act,
                       input logic [M*W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] shrink_ref(input logic [W-1:0] x, input logic [W-1:0] lam);
        int xi;
        int mag;
        int li;
        int r;
        xi  = int'($signed(x));
        mag = (xi < 0) ? -xi : xi;
        li  = int'({1'b0, lam});
        r   = (mag > li) ? (mag - li) : 0;
        if (xi < 0) r = -r;
        return W'(r);
    endfunction

    function automatic logic [W-1:0] pick_word(input logic [W-1:0] lam);
        int sel;
        sel = int'($urandom % 8);
        case (sel)
            0: return {1'b1, {(W-1){1'b0}}};
            1: return lam;
            2: return ~lam + 1'b1;
            3: return lam + 1'b1;
            4: return '0;
            default: return W'($urandom);
        endcase
    endfunction

    task automatic fill_mem(input logic [W-1:0] lam);
        for (int a = 0; a < DEPTH; a++) begin
            for (int m = 0; m < M; m++) mem[a][m*W +: W] = pick_word(lam);
        end
    endtask

    task automatic run_pass(input logic [W-1:0] pd, input logic [W-1:0] plam,
                            input int pvb, input int pbb, input int prows, input int ptail,
                            input bit disturb, input string btag);
        int rr;
        int tl;
        logic [M-1:0] mk;
        logic [W-1:0] vn;
        rr = (prows == 0) ? 1 : prows;
        tl = (ptail == 0 || ptail > M) ? M : ptail;
        for (int a = 0; a < DEPTH; a++) begin
            snap[a] = mem[a];
            expm[a] = mem[a];
        end
        for (int r = 0; r < rr; r++) begin
            for (int m = 0; m < M; m++) begin
                if (r < rr - 1 || m < tl) begin
                    vn = snap[pvb + r][m*W +: W] + pd;
                    expm[pvb + r][m*W +: W] = vn;
                    expm[pbb + r][m*W +: W] = shrink_ref(vn, plam);
                end
            end
        end
        @(negedge clk);
        d = pd; thresh = plam; v_base = AW'(pvb); b_base = AW'(pbb);
        row_cnt = TW'(prows); tail_cnt = CW'(ptail); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n <= 2*rr + 3; n++) begin
            bit exp_rd;
            int exp_ra;
            logic [M-1:0] exp_we;
            int exp_wa;
            bit isv;
            int wr;
            exp_rd = (n == 1) || (n >= 3 && ((n - 3) % 2 == 0) && ((n - 3) / 2 < rr - 1));
            exp_ra = (n == 1) ? pvb : pvb + (n - 3) / 2 + 1;
            chk(b_rd_en == exp_rd, "R3 read strobe", M*W'(b_rd_en), M*W'(exp_rd));
            if (exp_rd && b_rd_en)
                chk(b_rd_addr == AW'(exp_ra), "R3 read address", M*W'(b_rd_addr), M*W'(exp_ra));
            exp_we = '0;
            exp_wa = 0;
            isv = 0;
            wr = 0;
            if (n >= 3 && n <= 2*rr + 2) begin
                wr  = (n - 3) / 2;
                isv = ((n - 3) % 2 == 0);
                for (int m = 0; m < M; m++) exp_we[m] = (wr < rr - 1) || (m < tl);
                exp_wa = isv ? pvb + wr : pbb + wr;
            end
            mk = exp_we;
            chk(a_wr_en == mk, "R7 lane write enables", M*W'(a_wr_en), M*W'(mk));
            if (mk != '0) begin
                chk(a_wr_addr == AW'(exp_wa), isv ? "R4 v address" : "R5 beta address",
                    M*W'(a_wr_addr), M*W'(exp_wa));
                for (int m = 0; m < M; m++) begin
                    if (mk[m]) begin
                        vn = isv ? expm[pvb + wr][m*W +: W] : expm[pbb + wr][m*W +: W];
                        chk(a_wr_data[m*W +: W] == vn, isv ? "R4 v data" : btag,
                            M*W'(a_wr_data[m*W +: W]), M*W'(vn));
                    end
                end
            end
            chk(done == (n == 2*rr + 3), "R2 done timing", M*W'(done), M*W'(n == 2*rr + 3));
            if (disturb && n == 0) begin
                // R8: a new start and fresh inputs while busy must change nothing.
                start = 1'b1; d = ~pd; thresh = plam ^ 20'h5a5a5;
                v_base = AW'(pbb); b_base = AW'(pvb);
                row_cnt = TW'(rr + 3); tail_cnt = CW'((tl % M) + 1);
            end
            if (disturb && n == 2) start = 1'b0;
            @(negedge clk);
        end
        chk(done == 1'b0 && b_rd_en == 1'b0, "R2 idle after pass",
            M*W'({done, b_rd_en}), '0);
        for (int a = 0; a < DEPTH; a++)
            chk(mem[a] == expm[a], disturb ? "R8 memory image" : "R7 memory image",
                mem[a], expm[a]);
    endtask

    initial begin
        void'($urandom(32'h1d2c3b4a));
        for (int a = 0; a < DEPTH; a++) mem[a] = '0;
        repeat (3) @(negedge clk);
        chk(b_rd_en == 1'b0 && a_wr_en == '0 && done == 1'b0, "R1 outputs in reset",
            M*W'({b_rd_en, a_wr_en, done}), '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(b_rd_en == 1'b0 && a_wr_en == '0 && done == 1'b0, "R1 outputs idle after reset",
            M*W'({b_rd_en, a_wr_en, done}), '0);

        // Directed corners.
        fill_mem(20'd300);
        run_pass(20'd5, 20'd300, 0, 32, 1, 1, 0, "R5 beta single row");
        fill_mem(20'd0);
        run_pass(20'h00000, 20'd0, 4, 40, 3, 4, 0, "R6 zero threshold identity");
        fill_mem(20'd1000);
        run_pass(20'hfff00, 20'd1000, 2, 33, 16, 0, 0, "R6 threshold corners");
        fill_mem(20'h7ffff);
        run_pass(20'h7ffff, 20'h7ffff, 10, 50, 5, 6, 0, "R6 large threshold");
        fill_mem(20'd17);
        run_pass(20'h80000, 20'd17, 0, 32, 0, 2, 0, "R5 beta zero rows");
        fill_mem(20'd64);
        run_pass(20'd64, 20'd64, 7, 45, 6, 3, 1, "R8 beta disturbed");

        // Random passes.
        for (int i = 0; i < 24; i++) begin
            int rows;
            int vb;
            int bb;
            logic [W-1:0] lam;
            rows = 1 + int'($urandom % 16);
            vb   = int'($urandom % (33 - rows));
            bb   = 32 + int'($urandom % (33 - rows));
            lam  = ($urandom % 2 == 0) ? W'($urandom % 4096) : W'($urandom);
            fill_mem(lam);
            run_pass(W'($urandom), lam, vb, bb, rows, int'($urandom % 8), (i % 5) == 0,
                     "R5 beta random");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule